// File: doc/BRIEF.md
# Memory Alias Table Violation Detector

This block stands in for a load-store queue in a small out-of-order core. It does not forward store data to loads, and it never holds a load back behind an older store. Loads issue speculatively. The block keeps a small table of entries selected by an index taken from the memory address. Each entry holds a saturating count of in-flight loads and a conflict flag. A load that executes raises its entry's count. A store that commits while that count is nonzero marks the entry as conflicted. When a load later commits and finds its entry marked, the block asks the pipeline to flush.

The index is taken from a few address bits, so unrelated addresses can share an entry. Such a collision produces a false conflict, which is handled like a real one by a flush. The block does no recovery of its own. When a flush happens, whether it comes from its own request or from the pipeline's flush input, the whole table returns to zero, and the core resumes execution.

Top module: `alias_guard`

## Requirements
- R1: With the default index mode, the entry index is address bits [IDX_W-1:0], which gives 8 entries by default. Addresses 0x13 and 0x0B both select entry 3.
- R2: A valid load-execute increments the count of its entry.
- R3: A valid store-commit sets the flag of its entry if that entry's count is nonzero. If the count is zero, the store-commit has no effect.
- R4: A valid load-commit whose entry flag is set makes `flush_req` go high in the next cycle, for exactly one cycle. Otherwise `flush_req` stays low.
- R5: A valid load-commit whose entry flag is clear decrements that entry's count. A flag is cleared whenever its count reaches zero.
- R6: If a load-execute and a load-commit select the same entry in the same cycle, that entry's count is unchanged.
- R7: Counts saturate at 2**CNT_W-1 and do not wrap. A saturated count stays saturated, and so counts as nonzero, until the table is cleared.
- R8: In a cycle where `flush_req` or `flush_in` is high, the whole table is cleared at the next edge. All load and store inputs of that cycle are ignored, and no new flush is requested.
- R9: A synchronous active-high `rst` clears the table and drives `flush_req` low.
- R10: Different addresses that map to the same entry share it, so a store to one of them can cause a flush for a load to the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_in | input | 1 | Pipeline flush; clears the table |
| ld_exec_valid | input | 1 | A load executes this cycle |
| ld_exec_addr | input | ADDR_W | Address of the executing load |
| ld_commit_valid | input | 1 | A load commits this cycle |
| ld_commit_addr | input | ADDR_W | Address of the committing load |
| st_commit_valid | input | 1 | A store commits this cycle |
| st_commit_addr | input | ADDR_W | Address of the committing store |
| flush_req | output | 1 | Registered one-cycle flush request |

## Verification
The plain sequence of execute, then store, then commit must flush. The same sequence with the store placed before the execute must not, and this separates a nonzero-count test from a blind flag set. Other patterns check the corner rules of the count through later flush outcomes:
- an execute and a commit to one entry in the same cycle;
- a commit that brings the count back to zero;
- more executes than the count can hold.

Inputs applied during a flush cycle, and addresses that differ only in their upper bits, show whether the table was really ignored and whether entries are shared. A long random stretch with a small address range then compares every cycle against a reference model of the table.

// File: rtl/alias_guard_pkg.sv
package alias_guard_pkg;
  typedef enum logic {
    IDX_LOW = 1'b0,
    IDX_XOR = 1'b1
  } idx_mode_e;
endpackage

// File: rtl/alias_guard_hash.sv
module alias_guard_hash
  import alias_guard_pkg::*;
#(
  parameter int        ADDR_W   = 32,
  parameter int        IDX_W    = 3,
  parameter idx_mode_e IDX_MODE = IDX_LOW
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  generate
    if (IDX_MODE == IDX_XOR) begin : g_xor
      always_comb begin
        idx = '0;
        for (int b = 0; b < ADDR_W; b++) begin
          idx[b % IDX_W] = idx[b % IDX_W] ^ addr[b];
        end
      end
    end else begin : g_low
      assign idx = addr[IDX_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/alias_guard_entry.sv
module alias_guard_entry #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             inc,
  input  logic             commit_hit,
  input  logic             store_hit,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             flag_q, flag_nx;
  logic             dec, sat, live;

  always_comb begin
    dec    = commit_hit && !flag_q;
    sat    = (cnt_q == CMAX);
    live   = (cnt_q != '0);
    cnt_nx = cnt_q;
    if (!sat) begin
      if (inc && !dec) begin
        cnt_nx = cnt_q + 1'b1;
      end else if (dec && !inc && live) begin
        cnt_nx = cnt_q - 1'b1;
      end
    end
    flag_nx = (flag_q || (store_hit && live)) && (cnt_nx != '0);
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nx;
      flag_q <= flag_nx;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/alias_guard.sv
module alias_guard
  import alias_guard_pkg::*;
#(
  parameter int        ADDR_W   = 32,
  parameter int        IDX_W    = 3,
  parameter int        CNT_W    = 3,
  parameter idx_mode_e IDX_MODE = IDX_LOW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush_in,
  input  logic              ld_exec_valid,
  input  logic [ADDR_W-1:0] ld_exec_addr,
  input  logic              ld_commit_valid,
  input  logic [ADDR_W-1:0] ld_commit_addr,
  input  logic              st_commit_valid,
  input  logic [ADDR_W-1:0] st_commit_addr,
  output logic              flush_req
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [IDX_W-1:0]         ex_idx, lc_idx, sc_idx;
  logic [ENTRIES-1:0]       flags;
  logic [ENTRIES*CNT_W-1:0] cnt_flat;
  logic                     clr_tab;
  logic                     viol;

  alias_guard_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .IDX_MODE(IDX_MODE))
    u_hash_ex (.addr(ld_exec_addr), .idx(ex_idx));
  alias_guard_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .IDX_MODE(IDX_MODE))
    u_hash_lc (.addr(ld_commit_addr), .idx(lc_idx));
  alias_guard_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .IDX_MODE(IDX_MODE))
    u_hash_sc (.addr(st_commit_addr), .idx(sc_idx));

  assign clr_tab = rst || flush_in || flush_req;

  generate
    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      alias_guard_entry #(.CNT_W(CNT_W)) u_ent (
        .clk        (clk),
        .clr        (clr_tab),
        .inc        (ld_exec_valid   && (ex_idx == IDX_W'(i))),
        .commit_hit (ld_commit_valid && (lc_idx == IDX_W'(i))),
        .store_hit  (st_commit_valid && (sc_idx == IDX_W'(i))),
        .cnt_o      (cnt_flat[i*CNT_W +: CNT_W]),
        .flag_o     (flags[i])
      );
    end
  endgenerate

  assign viol = ld_commit_valid && flags[lc_idx] && !flush_in && !flush_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_req <= 1'b0;
    end else begin
      flush_req <= viol;
    end
  end
endmodule

// File: rtl/alias_guard_chk.sv
module alias_guard_chk #(
  parameter int ENTRIES = 8,
  parameter int CNT_W   = 3
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     flush_in,
  input logic                     ld_commit_valid,
  input logic                     flush_req,
  input logic [ENTRIES-1:0]       flags,
  input logic [ENTRIES*CNT_W-1:0] cnt_flat
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (!flush_req && cnt_flat == '0 && flags == '0));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    flush_req |=> !flush_req);

  a_r4_caused_by_commit: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> $past(ld_commit_valid));

  a_r8_table_cleared: assert property (@(posedge clk) disable iff (rst)
    (flush_req || flush_in) |=> (flags == '0 && cnt_flat == '0));

  generate
    for (genvar i = 0; i < ENTRIES; i++) begin : g_e
      a_r5_flag_needs_count: assert property (@(posedge clk) disable iff (rst)
        flags[i] |-> (cnt_flat[i*CNT_W +: CNT_W] != '0));
      a_r7_saturation_sticky: assert property (@(posedge clk) disable iff (rst)
        (cnt_flat[i*CNT_W +: CNT_W] == CMAX && !flush_req && !flush_in)
        |=> (cnt_flat[i*CNT_W +: CNT_W] == CMAX));
    end
  endgenerate
endmodule

bind alias_guard alias_guard_chk #(.ENTRIES(1 << IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .flush_in        (flush_in),
  .ld_commit_valid (ld_commit_valid),
  .flush_req       (flush_req),
  .flags           (flags),
  .cnt_flat        (cnt_flat)
);

// File: tb/alias_guard_tb.sv
module alias_guard_tb;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 3;
  localparam int CNT_W  = 3;
  localparam int NENT   = 1 << IDX_W;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              flush_in = 1'b0;
  logic              ld_exec_valid = 1'b0;
  logic [ADDR_W-1:0] ld_exec_addr = '0;
  logic              ld_commit_valid = 1'b0;
  logic [ADDR_W-1:0] ld_commit_addr = '0;
  logic              st_commit_valid = 1'b0;
  logic [ADDR_W-1:0] st_commit_addr = '0;
  logic              flush_req;

  alias_guard #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .flush_in(flush_in),
    .ld_exec_valid(ld_exec_valid), .ld_exec_addr(ld_exec_addr),
    .ld_commit_valid(ld_commit_valid), .ld_commit_addr(ld_commit_addr),
    .st_commit_valid(st_commit_valid), .st_commit_addr(st_commit_addr),
    .flush_req(flush_req)
  );

  always #5 clk = ~clk;

  typedef struct {
    bit    exp;
    string tag;
  } item_t;

  item_t q[$];
  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;

  int m_cnt [NENT];
  bit m_flg [NENT];
  bit m_req = 1'b0;

  // Monitor: compares flush_req two time units after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (flush_req !== it.exp) begin
          failures++;
          $display("FAIL %s flush_req actual=%0b expected=%0b at %0t",
                   it.tag, flush_req, it.exp, $time);
        end
      end
    end
  end

  // Driver: applies one cycle of stimulus and pushes the expected result.
  task automatic step(input bit fi, input bit ev, input logic [ADDR_W-1:0] ea,
                      input bit lc, input logic [ADDR_W-1:0] la,
                      input bit sc, input logic [ADDR_W-1:0] sa,
                      input string tag);
    int ei, li, si;
    bit clr, nreq;
    item_t it;
    @(negedge clk);
    flush_in        = fi;
    ld_exec_valid   = ev; ld_exec_addr   = ea;
    ld_commit_valid = lc; ld_commit_addr = la;
    st_commit_valid = sc; st_commit_addr = sa;
    ei = int'(ea[IDX_W-1:0]);
    li = int'(la[IDX_W-1:0]);
    si = int'(sa[IDX_W-1:0]);
    clr  = m_req || fi;
    nreq = !clr && lc && m_flg[li];
    for (int i = 0; i < NENT; i++) begin
      if (clr) begin
        m_cnt[i] = 0;
        m_flg[i] = 1'b0;
      end else begin
        bit inc, dec, st;
        int c;
        inc = ev && (ei == i);
        dec = lc && (li == i) && !m_flg[i];
        st  = sc && (si == i) && (m_cnt[i] != 0);
        c   = m_cnt[i];
        if (c != CMAX) begin
          if (inc && !dec) c = c + 1;
          else if (dec && !inc && c != 0) c = c - 1;
        end
        m_flg[i] = (m_flg[i] || st) && (c != 0);
        m_cnt[i] = c;
      end
    end
    m_req  = nreq;
    it.exp = nreq;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input string tag);
    step(0, 0, '0, 0, '0, 0, '0, tag);
  endtask

  task automatic ex(input logic [ADDR_W-1:0] a, input string tag);
    step(0, 1, a, 0, '0, 0, '0, tag);
  endtask

  task automatic lcm(input logic [ADDR_W-1:0] a, input string tag);
    step(0, 0, '0, 1, a, 0, '0, tag);
  endtask

  task automatic stc(input logic [ADDR_W-1:0] a, input string tag);
    step(0, 0, '0, 0, '0, 1, a, tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NENT; i++) begin
      m_cnt[i] = 0;
      m_flg[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    checks++;
    if (flush_req !== 1'b0) begin
      failures++;
      $display("FAIL R9 reset flush_req actual=%0b expected=0", flush_req);
    end
    rst = 1'b0;

    // R2 R3 R4: execute, conflicting store, commit -> one-cycle flush
    ex(32'h13, "R2"); stc(32'h13, "R3"); lcm(32'h13, "R4");
    idle("R4"); idle("R4");
    // R1: index from low bits; store to 0x14 (entry 4) leaves entry 3 alone
    ex(32'h13, "R1"); stc(32'h14, "R1"); lcm(32'h13, "R1"); idle("R1");
    // R1: upper bits ignored by the index: 0x103 hits entry 3
    ex(32'h13, "R1"); stc(32'h103, "R1"); lcm(32'h13, "R1"); idle("R1"); idle("R1");
    // R3: store to an entry with zero count has no effect
    stc(32'h25, "R3"); ex(32'h25, "R3"); lcm(32'h25, "R3"); idle("R3");
    // R5: commit returns count to zero; later store does not mark
    ex(32'h40, "R5"); lcm(32'h40, "R5"); stc(32'h40, "R5");
    ex(32'h40, "R5"); lcm(32'h40, "R5"); idle("R5");
    // R5: two in flight, one commits, store still marks, other flushes
    ex(32'h40, "R5"); ex(32'h40, "R5"); lcm(32'h40, "R5");
    stc(32'h40, "R5"); lcm(32'h40, "R5"); idle("R5"); idle("R5");
    // R6: execute and commit on one entry in the same cycle
    ex(32'h31, "R6");
    step(0, 1, 32'h31, 1, 32'h31, 0, '0, "R6");
    lcm(32'h31, "R6"); stc(32'h31, "R6"); ex(32'h31, "R6"); lcm(32'h31, "R6");
    idle("R6");
    // R7: saturation; nine executes then nine commits, count stays nonzero
    for (int k = 0; k < CMAX + 2; k++) ex(32'h22, "R7");
    for (int k = 0; k < CMAX + 2; k++) lcm(32'h22, "R7");
    stc(32'h22, "R7"); lcm(32'h22, "R7"); idle("R7"); idle("R7");
    // R8: inputs during the flush_req cycle are ignored
    ex(32'h17, "R8"); stc(32'h17, "R8"); lcm(32'h17, "R8");
    step(0, 1, 32'h5, 1, 32'h17, 0, '0, "R8");
    stc(32'h5, "R8"); lcm(32'h5, "R8"); idle("R8");
    // R8: flush_in clears, and suppresses a flagged commit
    ex(32'h6, "R8"); stc(32'h6, "R8");
    step(1, 0, '0, 1, 32'h6, 0, '0, "R8");
    lcm(32'h6, "R8"); idle("R8");
    ex(32'h7, "R8"); step(1, 0, '0, 0, '0, 0, '0, "R8");
    stc(32'h7, "R8"); lcm(32'h7, "R8"); idle("R8");
    // R10: aliasing addresses share an entry -> false positive flush
    ex(32'h0B, "R10"); stc(32'h13, "R10"); lcm(32'h0B, "R10");
    idle("R10"); idle("R10");
    // R4: random traffic over a small address range against the model
    for (int k = 0; k < 400; k++) begin
      step(($urandom_range(0, 29) == 0), 1'($urandom_range(0, 1)),
           ADDR_W'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
           ADDR_W'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
           ADDR_W'($urandom_range(0, 15)), "R4");
    end
    idle("R4"); idle("R4");
    @(posedge clk); #4;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule